// File: doc/BRIEF.md
# One-Time-Programmable Array Programming Interlock

This block sits between the CPU register bus and an on-chip one-time-programmable byte array. It holds one 8-bit control register and uses it to decide how each CPU access to the array window is treated. In normal operation, CPU reads of the window become array reads. In programming mode, CPU writes to the window load an address/data holding latch, and the array is closed to reads.

A programming-voltage-present input guards entry into programming mode. If that voltage goes away while the block is in programming mode, the block falls back to normal operation by itself. A program-power enable output tells the high-voltage switch to energise the array, and only while both the mode bit and the power-command bit are set.

Internally a three-state mode machine drives the behaviour:
- `MODE_READ`: normal operation.
- `MODE_ARMED`: programming mode with nothing latched yet.
- `MODE_HELD`: programming mode with an address/data pair held.

The transitions are:
- ENTER (`MODE_READ` to `MODE_ARMED`): a register write with the mode bit set while the voltage is present.
- CAPTURE (`MODE_ARMED` to `MODE_HELD`): an array write.
- RECAPTURE (`MODE_HELD` to `MODE_HELD`): a further array write.
- EXIT (`MODE_ARMED` or `MODE_HELD` to `MODE_READ`): a register write with the mode bit clear.
- DROP (`MODE_ARMED` or `MODE_HELD` to `MODE_READ`): the voltage is seen absent at a clock edge.

Top module: `otp_prog_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `prog_pwr_en` is 0 and `arr_held` is 0.
- R2: The control register sits at bus address 0x001D. Bit 7 is the programming-mode bit and bit 0 is the power-command bit. Bits 6..1 read as 0. Every read returns its data on `cpu_rdata` with `cpu_rvalid` high in the cycle after `cpu_rd`.
- R3: In normal mode, a read inside the array window (base 0x1000, 256 bytes) drives `arr_rd_en` high in the same cycle, with `arr_addr` equal to the window offset. It returns `arr_rdata` on the next cycle.
- R4: A register write with bit 7 set while `vpp_present` is 0 in normal mode is ignored completely, and the register keeps its value.
- R5: A register write with bit 7 set while `vpp_present` is 1 enters programming mode, and bit 7 then reads back as 1.
- R6: In programming mode, a write inside the array window loads its offset onto `arr_addr` and its data onto `arr_wdata`, and sets `arr_held`, from the next cycle on. A later window write replaces the held pair.
- R7: In programming mode, array reads return 0xFF and `arr_rd_en` stays 0.
- R8: In normal mode, writes to the array window have no effect, and `arr_held` stays 0.
- R9: `prog_pwr_en` is 1 exactly when bits 7 and 0 are both 1. Bit 0 alone is stored and reads back, but does not switch power on.
- R10: If `vpp_present` is 0 at a clock edge while the block is in programming mode, both bits read 0 after that edge and `prog_pwr_en` falls.
- R11: A register write with bit 7 clear leaves programming mode and clears `arr_held`. Array reads then return array contents again, including bytes programmed while power was on.
- R12: Reads of bus addresses that are neither the register nor the array window return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU bus address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | Read data valid, one cycle after cpu_rd |
| vpp_present | input | 1 | Programming voltage is present |
| arr_addr | output | 8 | Array address: the read offset in normal mode, the held offset in programming mode |
| arr_rd_en | output | 1 | Array read enable |
| arr_rdata | input | 8 | Array read data, one cycle after arr_rd_en |
| arr_wdata | output | 8 | Held programming data |
| arr_held | output | 1 | An address/data pair is held for programming |
| prog_pwr_en | output | 1 | Programming power enable to the array |

## Verification
The hardest situation to reach from the ports is a loss of programming voltage while power is actually applied to a held byte. Reaching it needs the whole sequence in order: voltage raised, mode entered, a window write captured, and the power bit set. The stimulus walks that sequence, keeps power on for several cycles so the array model burns the byte, and then drops `vpp_present` at a falling edge. Reading the register and the programmed byte back afterwards confirms that both bits cleared and that the burn stopped with the expected value in the array.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_ARMED = 2'd1,
        MODE_HELD  = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        RSRC_NONE    = 2'd0,
        RSRC_REG     = 2'd1,
        RSRC_ARRAY   = 2'd2,
        RSRC_BLOCKED = 2'd3
    } rsrc_e;

    localparam int MODE_BIT  = 7;
    localparam int POWER_BIT = 0;

endpackage

// File: rtl/otp_addr_dec.sv
module otp_addr_dec #(
    parameter int          AW        = 16,
    parameter int          OW        = 8,
    parameter int unsigned REG_ADDR  = 'h1D,
    parameter int unsigned ARR_BASE  = 'h1000,
    parameter int unsigned ARR_DEPTH = 256
) (
    input  logic [AW-1:0] addr,
    output logic          hit_reg,
    output logic          hit_arr,
    output logic [OW-1:0] offset
);
    localparam logic [AW-1:0] REG_V  = AW'(REG_ADDR);
    localparam logic [AW:0]   BASE_V = (AW+1)'(ARR_BASE);
    localparam logic [AW:0]   END_V  = (AW+1)'(ARR_BASE + ARR_DEPTH);

    logic [AW:0] addr_x;

    always_comb begin
        addr_x  = {1'b0, addr};
        hit_reg = (addr == REG_V);
        hit_arr = (addr_x >= BASE_V) && (addr_x < END_V);
        offset  = OW'(addr_x - BASE_V);
    end
endmodule

// File: rtl/otp_mode_fsm.sv
module otp_mode_fsm
    import otp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  reg_wr,
    input  logic  w_mode,
    input  logic  w_power,
    input  logic  arr_wr,
    input  logic  vpp_present,
    output mode_e mode,
    output logic  pgm_q,
    output logic  prog_mode,
    output logic  capture
);
    mode_e st_q, st_d;
    logic  pgm_d;
    logic  write_refused;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= MODE_READ;
            pgm_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            pgm_q <= pgm_d;
        end
    end

    always_comb begin
        write_refused = reg_wr && w_mode && !vpp_present;
        st_d  = st_q;
        pgm_d = pgm_q;
        unique case (st_q)
            MODE_READ: begin
                if (reg_wr && !write_refused) begin
                    pgm_d = w_power;
                    if (w_mode) st_d = MODE_ARMED;
                end
            end
            MODE_ARMED, MODE_HELD: begin
                if (!vpp_present) begin
                    st_d  = MODE_READ;
                    pgm_d = 1'b0;
                end else if (reg_wr) begin
                    pgm_d = w_power;
                    if (!w_mode) st_d = MODE_READ;
                end else if (arr_wr) begin
                    st_d = MODE_HELD;
                end
            end
            default: begin
                st_d  = MODE_READ;
                pgm_d = 1'b0;
            end
        endcase
    end

    always_comb begin
        mode      = st_q;
        prog_mode = (st_q != MODE_READ);
        capture   = (st_q != MODE_READ) && vpp_present && arr_wr && !reg_wr;
    end
endmodule

// File: rtl/otp_prog_latch.sv
module otp_prog_latch #(
    parameter int OW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [OW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic [OW-1:0] held_addr,
    output logic [DW-1:0] held_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_addr <= '0;
            held_data <= '0;
        end else if (capture) begin
            held_addr <= in_addr;
            held_data <= in_data;
        end
    end
endmodule

// File: rtl/otp_rd_steer.sv
module otp_rd_steer
    import otp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_rd,
    input  logic          hit_reg,
    input  logic          hit_arr,
    input  logic          prog_mode,
    input  logic [DW-1:0] reg_val,
    input  logic [DW-1:0] arr_rdata,
    output logic          arr_rd_en,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_rvalid
);
    rsrc_e         src_q, src_d;
    logic [DW-1:0] snap_q;

    always_comb begin
        arr_rd_en = cpu_rd && hit_arr && !prog_mode;
        if (!cpu_rd)                  src_d = RSRC_NONE;
        else if (hit_reg)             src_d = RSRC_REG;
        else if (hit_arr && prog_mode) src_d = RSRC_BLOCKED;
        else if (hit_arr)             src_d = RSRC_ARRAY;
        else                          src_d = RSRC_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q      <= RSRC_NONE;
            snap_q     <= '0;
            cpu_rvalid <= 1'b0;
        end else begin
            src_q      <= src_d;
            snap_q     <= reg_val;
            cpu_rvalid <= cpu_rd;
        end
    end

    always_comb begin
        unique case (src_q)
            RSRC_REG:     cpu_rdata = snap_q;
            RSRC_ARRAY:   cpu_rdata = arr_rdata;
            RSRC_BLOCKED: cpu_rdata = '1;
            default:      cpu_rdata = '0;
        endcase
    end
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
    import otp_pkg::*;
#(
    parameter int          AW        = 16,
    parameter int          DW        = 8,
    parameter int unsigned REG_ADDR  = 'h1D,
    parameter int unsigned ARR_BASE  = 'h1000,
    parameter int unsigned ARR_DEPTH = 256,
    localparam int         OW        = $clog2(ARR_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_wr,
    input  logic          cpu_rd,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_rvalid,
    input  logic          vpp_present,
    output logic [OW-1:0] arr_addr,
    output logic          arr_rd_en,
    input  logic [DW-1:0] arr_rdata,
    output logic [DW-1:0] arr_wdata,
    output logic          arr_held,
    output logic          prog_pwr_en
);
    logic          hit_reg, hit_arr;
    logic [OW-1:0] offset;
    mode_e         mode_w;
    logic          pgm_w, prog_mode, capture;
    logic [OW-1:0] held_addr;
    logic [DW-1:0] reg_val;

    otp_addr_dec #(
        .AW(AW), .OW(OW), .REG_ADDR(REG_ADDR),
        .ARR_BASE(ARR_BASE), .ARR_DEPTH(ARR_DEPTH)
    ) u_dec (
        .addr(cpu_addr), .hit_reg(hit_reg), .hit_arr(hit_arr), .offset(offset)
    );

    otp_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(cpu_wr && hit_reg),
        .w_mode(cpu_wdata[MODE_BIT]),
        .w_power(cpu_wdata[POWER_BIT]),
        .arr_wr(cpu_wr && hit_arr),
        .vpp_present(vpp_present),
        .mode(mode_w), .pgm_q(pgm_w), .prog_mode(prog_mode), .capture(capture)
    );

    otp_prog_latch #(.OW(OW), .DW(DW)) u_latch (
        .clk(clk), .rst_n(rst_n), .capture(capture),
        .in_addr(offset), .in_data(cpu_wdata),
        .held_addr(held_addr), .held_data(arr_wdata)
    );

    always_comb begin
        reg_val            = '0;
        reg_val[MODE_BIT]  = prog_mode;
        reg_val[POWER_BIT] = pgm_w;
        arr_addr           = prog_mode ? held_addr : offset;
        arr_held           = (mode_w == MODE_HELD);
        prog_pwr_en        = prog_mode && pgm_w;
    end

    otp_rd_steer #(.DW(DW)) u_rd (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd),
        .hit_reg(hit_reg), .hit_arr(hit_arr), .prog_mode(prog_mode),
        .reg_val(reg_val), .arr_rdata(arr_rdata),
        .arr_rd_en(arr_rd_en), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid)
    );
endmodule

// File: rtl/otp_prog_ctrl_chk.sv
module otp_prog_ctrl_chk
    import otp_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  vpp_present,
    input logic  cpu_wr,
    input logic  prog_pwr_en,
    input logic  arr_rd_en,
    input logic  arr_held,
    input mode_e mode,
    input logic  pgm
);
    a_r4_no_entry_without_vpp: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_READ && !vpp_present) |=> (mode == MODE_READ));

    a_r10_vpp_loss_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_READ && !vpp_present) |=> (mode == MODE_READ && !pgm && !prog_pwr_en));

    a_r7_no_array_read_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_READ) |-> !arr_rd_en);

    a_r6_held_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_held) |-> $past(cpu_wr));

    a_r9_power_had_vpp: assert property (@(posedge clk) disable iff (!rst_n)
        prog_pwr_en |-> $past(vpp_present));
endmodule

bind otp_prog_ctrl otp_prog_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .vpp_present(vpp_present), .cpu_wr(cpu_wr),
    .prog_pwr_en(prog_pwr_en), .arr_rd_en(arr_rd_en), .arr_held(arr_held),
    .mode(mode_w), .pgm(pgm_w)
);

// File: tb/sim_otp_prog_ctrl.sv
module sim_otp_prog_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_rvalid;
    logic        vpp_present = 1'b0;
    logic [7:0]  arr_addr;
    logic        arr_rd_en;
    logic [7:0]  arr_rdata = '0;
    logic [7:0]  arr_wdata;
    logic        arr_held;
    logic        prog_pwr_en;

    int   vectors = 0, miscompares = 0;
    bit   done = 0;
    logic [7:0] mem [256];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    otp_prog_ctrl u0 (.*);

    function automatic logic [7:0] init_v(int i);
        return 8'(i) ^ 8'hA5;
    endfunction

    initial for (int i = 0; i < 256; i++) mem[i] = init_v(i);

    always @(posedge clk) begin
        if (arr_rd_en) arr_rdata <= mem[arr_addr];
        if (prog_pwr_en && arr_held) mem[arr_addr] <= mem[arr_addr] & arr_wdata;
    end

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) if (cpu_rvalid) begin
        if (exp_q.size() == 0) check("R2 unexpected rvalid", 16'd1, 16'd0);
        else check(tag_q.pop_front(), {8'h00, cpu_rdata}, {8'h00, exp_q.pop_front()});
    end

    task automatic wr(logic [15:0] a, logic [7:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, logic [7:0] exp, string tag,
                      bit probe = 0, logic en = 0, logic [7:0] pa = 0);
        cpu_addr = a; cpu_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        #1;
        if (probe) begin
            check({tag, " rd_en"}, {15'd0, arr_rd_en}, {15'd0, en});
            if (en) check({tag, " addr"}, {8'h00, arr_addr}, {8'h00, pa});
        end
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pwr", {15'd0, prog_pwr_en}, 16'd0);
        check("R1 held", {15'd0, arr_held}, 16'd0);
        rd(16'h001D, 8'h00, "R1 reg reset");
        // R3 normal reads
        rd(16'h1003, init_v(3), "R3 read 3", 1, 1'b1, 8'h03);
        rd(16'h1000, init_v(0), "R3 read 0", 1, 1'b1, 8'h00);
        rd(16'h10FF, init_v(255), "R3 read 255", 1, 1'b1, 8'hFF);
        // R12 unmapped
        rd(16'h0050, 8'h00, "R12 unmapped");
        rd(16'h1100, 8'h00, "R12 above window", 1, 1'b0);
        // R8 window write in normal mode
        wr(16'h1040, 8'h00);
        check("R8 held", {15'd0, arr_held}, 16'd0);
        rd(16'h1040, init_v(64), "R8 unchanged");
        // R4 entry refused without voltage
        wr(16'h001D, 8'h81);
        check("R4 pwr", {15'd0, prog_pwr_en}, 16'd0);
        rd(16'h001D, 8'h00, "R4 reg unchanged");
        // R9 power bit alone
        wr(16'h001D, 8'h01);
        check("R9 pwr off", {15'd0, prog_pwr_en}, 16'd0);
        rd(16'h001D, 8'h01, "R9 bit0 stored");
        // R5 / R2 entry with voltage
        vpp_present = 1'b1;
        wr(16'h001D, 8'hFE);
        rd(16'h001D, 8'h80, "R5 R2 mode bit set");
        check("R5 pwr", {15'd0, prog_pwr_en}, 16'd0);
        // R7 blocked reads
        rd(16'h1003, 8'hFF, "R7 blocked", 1, 1'b0);
        // R6 capture
        wr(16'h1010, 8'h0F);
        check("R6 held", {15'd0, arr_held}, 16'd1);
        check("R6 addr", {8'h00, arr_addr}, 16'h0010);
        check("R6 data", {8'h00, arr_wdata}, 16'h000F);
        wr(16'h1011, 8'h3C);
        check("R6 re-addr", {8'h00, arr_addr}, 16'h0011);
        check("R6 re-data", {8'h00, arr_wdata}, 16'h003C);
        // R9 power on
        wr(16'h001D, 8'h81);
        check("R9 pwr on", {15'd0, prog_pwr_en}, 16'd1);
        repeat (4) @(negedge clk);
        wr(16'h001D, 8'h80);
        check("R9 pwr off again", {15'd0, prog_pwr_en}, 16'd0);
        // R11 exit
        wr(16'h001D, 8'h00);
        check("R11 held clear", {15'd0, arr_held}, 16'd0);
        rd(16'h1011, init_v(17) & 8'h3C, "R11 programmed byte");
        rd(16'h1010, init_v(16), "R11 untouched byte");
        // R10 voltage loss while burning
        wr(16'h001D, 8'h80);
        wr(16'h1020, 8'hF0);
        wr(16'h001D, 8'h81);
        check("R10 pwr on", {15'd0, prog_pwr_en}, 16'd1);
        repeat (3) @(negedge clk);
        vpp_present = 1'b0;
        @(negedge clk);
        check("R10 pwr dropped", {15'd0, prog_pwr_en}, 16'd0);
        check("R10 held dropped", {15'd0, arr_held}, 16'd0);
        rd(16'h001D, 8'h00, "R10 bits cleared");
        rd(16'h1020, init_v(32) & 8'hF0, "R10 burn result");
        repeat (3) @(negedge clk);
        check("R2 queue drained", 16'(exp_q.size()), 16'd0);
        finish_run();
    end
endmodule